// File: doc/BRIEF.md
# Bit-Field Extract Execution Unit

This unit decodes and executes one family of custom R-type instructions that sits in the custom-0 major opcode space. Each instruction takes a contiguous field of 1 to 8 bits out of the first source operand, starting at a bit offset, and returns it zero-extended to 32 bits. The offset comes from one of two places. It is either the full 32-bit value of the second source operand, or the 5-bit second-source index field of the instruction word read as an immediate. Source positions past bit 31 read as zero; they do not wrap.

The instruction word and both operand values enter on a valid/ready stream. Results leave on a second valid/ready stream carrying the destination index, the result, a write-enable and an illegal-instruction flag. Each output beat is registered one cycle after the input is accepted.

Back-pressure rules:
- A beat is accepted when `in_valid` and `in_ready` are both high at a clock edge.
- `in_ready` is high when the output slot is empty or is being drained in the same cycle.
- An output beat holds all of its fields unchanged until `out_ready` takes it.
- An accepted instruction outside the custom-0 opcode is consumed and produces no output beat.

Top module: `bfx_unit`

## Requirements
- R1: An instruction is recognised only when bits 6:0 equal 0x0B. An accepted word with any other opcode produces no output beat.
- R2: The field width is instruction bits 28:26 plus one, which gives 1 to 8. Result bits at and above the width are zero.
- R3: When bits 14:12 equal 0, the offset is the full 32-bit second operand with no masking. An offset of 32 or more yields an all-zero result.
- R4: When bits 14:12 equal 4, the offset is instruction bits 24:20 taken as an unsigned immediate, and the second operand is ignored.
- R5: Result bit i, for i below the width, equals first-operand bit (offset + i). It is zero wherever offset + i exceeds 31.
- R6: When the opcode matches and bits 14:12 are neither 0 nor 4, the beat carries illegal = 1, write-enable = 0 and a zero result.
- R7: `out_rd` carries instruction bits 11:7. Write-enable is 0 whenever that index is 0.
- R8: A recognised instruction accepted at a clock edge appears with `out_valid` high in the following cycle.
- R9: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, every output field holds its value.
- R10: A synchronous active-high reset clears `out_valid`, write-enable and the illegal flag.
- R11: Instruction bits 31:29 and bit 25 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take an input beat |
| in_instr | input | 32 | Instruction word |
| in_rs1_val | input | 32 | First source operand (field source) |
| in_rs2_val | input | 32 | Second source operand (register offset) |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_rd | output | 5 | Destination register index |
| out_result | output | 32 | Zero-extended extracted field |
| out_wr_en | output | 1 | Destination write permitted |
| out_illegal | output | 1 | Opcode matched but the variant code is undefined |

## Verification
Every result is due exactly one clock edge after its input is accepted: it appears at the next falling edge, and it stays there for as long as `out_ready` is held low. `in_ready` is combinational and is checked in the same cycle the inputs are driven. The bench drives inputs at the falling edge and advances a behavioural model of the output slot at the same point the hardware would. It then compares every output field at the next falling edge. As a result, each stall, drain and refill is checked in the cycle it takes effect.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam logic [6:0] OPC_CUSTOM0 = 7'h0B;
  localparam logic [2:0] F3_REG_OFS  = 3'd0;
  localparam logic [2:0] F3_IMM_OFS  = 3'd4;
  localparam int unsigned WSEL_BITS  = 3;
  localparam int unsigned WIDTH_BITS = WSEL_BITS + 1;

  typedef enum logic [1:0] {
    OFS_FROM_REG = 2'd0,
    OFS_FROM_IMM = 2'd1,
    OFS_NONE     = 2'd2
  } ofs_src_e;

  typedef struct packed {
    logic                  hit;
    logic                  legal;
    ofs_src_e              src;
    logic [4:0]            rd;
    logic [4:0]            imm;
    logic [WIDTH_BITS-1:0] width;
  } bfx_dec_t;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
  import bfx_pkg::*;
(
  input  logic [6:0]           opcode,
  input  logic [2:0]           funct3,
  input  logic [WSEL_BITS-1:0] wsel,
  input  logic [4:0]           rd_field,
  input  logic [4:0]           rs2_field,
  output bfx_dec_t             dec
);
  always_comb begin
    dec.hit   = (opcode == OPC_CUSTOM0);
    dec.rd    = rd_field;
    dec.imm   = rs2_field;
    dec.width = {1'b0, wsel} + WIDTH_BITS'(1);
    unique case (funct3)
      F3_REG_OFS: begin dec.src = OFS_FROM_REG; dec.legal = 1'b1; end
      F3_IMM_OFS: begin dec.src = OFS_FROM_IMM; dec.legal = 1'b1; end
      default:    begin dec.src = OFS_NONE;     dec.legal = 1'b0; end
    endcase
  end
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned MAX_W = 8,
  parameter int unsigned WW    = 4
) (
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] offset,
  input  logic [WW-1:0]   width,
  output logic [XLEN-1:0] field
);
  localparam int unsigned SW = XLEN + 1;
  localparam int unsigned IW = $clog2(XLEN);

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    if (i < MAX_W) begin : g_live
      logic [SW-1:0] pos;
      logic          in_range;
      logic          in_width;
      assign pos      = {1'b0, offset} + SW'(i);
      assign in_range = (pos < SW'(XLEN));
      assign in_width = (WW'(i) < width);
      assign field[i] = in_range && in_width && src[pos[IW-1:0]];
    end else begin : g_zero
      assign field[i] = 1'b0;
    end
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned MAX_W = 1 << WSEL_BITS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_instr,
  input  logic [XLEN-1:0] in_rs1_val,
  input  logic [XLEN-1:0] in_rs2_val,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [4:0]      out_rd,
  output logic [XLEN-1:0] out_result,
  output logic            out_wr_en,
  output logic            out_illegal
);
  bfx_dec_t        dec;
  logic [XLEN-1:0] ofs;
  logic [XLEN-1:0] field;
  logic            accept;

  bfx_decode u_dec (
    .opcode    (in_instr[6:0]),
    .funct3    (in_instr[14:12]),
    .wsel      (in_instr[28:26]),
    .rd_field  (in_instr[11:7]),
    .rs2_field (in_instr[24:20]),
    .dec       (dec)
  );

  assign ofs = (dec.src == OFS_FROM_IMM) ? XLEN'(dec.imm) : in_rs2_val;

  bfx_extract #(.XLEN(XLEN), .MAX_W(MAX_W), .WW(WIDTH_BITS)) u_ext (
    .src    (in_rs1_val),
    .offset (ofs),
    .width  (dec.width),
    .field  (field)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_wr_en   <= 1'b0;
      out_illegal <= 1'b0;
      out_rd      <= '0;
      out_result  <= '0;
    end else if (accept && dec.hit) begin
      out_valid   <= 1'b1;
      out_rd      <= dec.rd;
      out_result  <= dec.legal ? field : '0;
      out_illegal <= !dec.legal;
      out_wr_en   <= dec.legal && (dec.rd != 5'd0);
    end else if (out_ready) begin
      out_valid   <= 1'b0;
      out_wr_en   <= 1'b0;
      out_illegal <= 1'b0;
    end
  end
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [6:0]      opcode,
  input logic            out_valid,
  input logic            out_ready,
  input logic [4:0]      out_rd,
  input logic [XLEN-1:0] out_result,
  input logic            out_wr_en,
  input logic            out_illegal
);
  assert_wren_rd_R7: assert property (@(posedge clk) disable iff (rst)
    out_wr_en |-> (out_valid && out_rd != 5'd0));

  assert_illegal_nowrite_R6: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (!out_wr_en && out_result == '0 && out_valid));

  assert_field_narrow_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_result[XLEN-1:8] == '0));

  assert_accept_latency_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && opcode == 7'h0B) |=> out_valid);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_rd) && $stable(out_wr_en) && $stable(out_illegal)));

  assert_foreign_drop_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && opcode != 7'h0B && out_ready) |=> !out_valid);
endmodule

bind bfx_unit bfx_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .opcode     (in_instr[6:0]),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_rd     (out_rd),
  .out_result (out_result),
  .out_wr_en  (out_wr_en),
  .out_illegal(out_illegal)
);

// File: tb/test_bfx_unit.sv
module test_bfx_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [31:0] in_rs1_val = '0;
  logic [31:0] in_rs2_val = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [4:0]  out_rd;
  logic [31:0] out_result;
  logic        out_wr_en;
  logic        out_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model of the output slot
  bit          m_valid = 0;
  logic [4:0]  m_rd = '0;
  logic [31:0] m_res = '0;
  bit          m_we = 0;
  bit          m_ill = 0;

  always #10 clk = ~clk;

  bfx_unit i_bfx_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_rs1_val(in_rs1_val), .in_rs2_val(in_rs2_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_rd(out_rd),
    .out_result(out_result), .out_wr_en(out_wr_en), .out_illegal(out_illegal)
  );

  function automatic logic [31:0] enc(input logic [2:0] f3, input int w,
      input logic [4:0] rd, input logic [4:0] rs2f, input logic [3:0] junk);
    logic [2:0] ws = 3'(w - 1);
    return {junk[3:1], ws, junk[0], rs2f, 5'd3, f3, rd, 7'h0B};
  endfunction

  function automatic logic [31:0] ref_field(input logic [31:0] a,
      input longint ofs, input int w);
    logic [31:0] r = '0;
    for (int i = 0; i < w; i++) begin
      longint p = ofs + i;
      if (p < 32) r[i] = a[int'(p)];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
      input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(out_valid == m_valid, tag, "out_valid", 32'(out_valid), 32'(m_valid));
    chk(out_wr_en == m_we, tag, "out_wr_en", 32'(out_wr_en), 32'(m_we));
    chk(out_illegal == m_ill, tag, "out_illegal", 32'(out_illegal), 32'(m_ill));
    if (m_valid) begin
      chk(out_rd == m_rd, tag, "out_rd", 32'(out_rd), 32'(m_rd));
      chk(out_result == m_res, tag, "out_result", out_result, m_res);
    end
  endtask

  // drive at the falling edge, advance model, compare at the next falling edge
  task automatic step(input bit v, input logic [31:0] ins,
      input logic [31:0] a, input logic [31:0] b, input bit rdy, input string tag);
    bit acc;
    bit hit;
    logic [2:0] f3;
    int w;
    longint ofs;
    in_valid = v; in_instr = ins; in_rs1_val = a; in_rs2_val = b; out_ready = rdy;
    #1;
    chk(in_ready == (!m_valid || rdy), "R9", "in_ready", 32'(in_ready),
        32'(!m_valid || rdy));
    acc = v && (!m_valid || rdy);
    hit = (ins[6:0] == 7'h0B);
    f3  = ins[14:12];
    w   = int'(ins[28:26]) + 1;
    ofs = (f3 == 3'd4) ? longint'(ins[24:20]) : longint'(b);
    @(posedge clk);
    @(negedge clk);
    if (acc && hit) begin
      m_valid = 1;
      m_rd    = ins[11:7];
      m_ill   = !(f3 == 3'd0 || f3 == 3'd4);
      m_res   = m_ill ? 32'd0 : ref_field(a, ofs, w);
      m_we    = !m_ill && (ins[11:7] != 5'd0);
    end else if (rdy) begin
      m_valid = 0; m_we = 0; m_ill = 0;
    end
    compare(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] pat;
    pat = 32'hA5C3_96F1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R10");

    // R3 register offset, several offsets and widths
    step(1, enc(3'd0, 8, 5'd1, 5'd2, 4'h0), pat, 32'd0, 1, "R3");
    step(1, enc(3'd0, 4, 5'd2, 5'd2, 4'h0), pat, 32'd5, 1, "R5");
    step(1, enc(3'd0, 8, 5'd3, 5'd2, 4'h0), pat, 32'd28, 1, "R5");
    step(1, enc(3'd0, 8, 5'd4, 5'd2, 4'h0), 32'hFFFF_FFFF, 32'd31, 1, "R5");
    step(1, enc(3'd0, 8, 5'd5, 5'd2, 4'h0), 32'hFFFF_FFFF, 32'd32, 1, "R3");
    step(1, enc(3'd0, 8, 5'd6, 5'd2, 4'h0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R3");
    step(1, enc(3'd0, 8, 5'd6, 5'd1, 4'h0), 32'hFFFF_FFFF, 32'h0000_0100, 1, "R3");
    // R2 widths 1..8 of all-ones
    for (int w = 1; w <= 8; w++)
      step(1, enc(3'd0, w, 5'd7, 5'd0, 4'h0), 32'hFFFF_FFFF, 32'd3, 1, "R2");
    // R4 immediate offset, rs2 value ignored
    step(1, enc(3'd4, 8, 5'd8, 5'd16, 4'h0), pat, 32'hFFFF_FFFF, 1, "R4");
    step(1, enc(3'd4, 6, 5'd9, 5'd29, 4'h0), 32'hFFFF_FFFF, 32'd0, 1, "R4");
    step(1, enc(3'd4, 3, 5'd9, 5'd31, 4'h0), 32'h8000_0000, 32'd0, 1, "R4");
    // R6 undefined variant codes
    for (int f = 1; f < 8; f++)
      if (f != 4) step(1, enc(3'(f), 8, 5'd10, 5'd1, 4'h0), pat, 32'd1, 1, "R6");
    // R7 rd zero
    step(1, enc(3'd0, 8, 5'd0, 5'd0, 4'h0), pat, 32'd0, 1, "R7");
    step(1, enc(3'd4, 8, 5'd0, 5'd4, 4'h0), pat, 32'd0, 1, "R7");
    // R11 ignored bits set
    step(1, enc(3'd0, 5, 5'd11, 5'd2, 4'hF), pat, 32'd9, 1, "R11");
    step(1, enc(3'd4, 5, 5'd11, 5'd9, 4'hA), pat, 32'd0, 1, "R11");
    // R1 foreign opcode: no beat
    step(1, enc(3'd0, 8, 5'd12, 5'd2, 4'h0) ^ 32'h1, pat, 32'd0, 1, "R1");
    step(1, {25'h1ABCDE, 7'h33}, pat, 32'd0, 1, "R1");
    step(0, '0, '0, '0, 1, "R8");
    // R9 stall: hold, then refuse input, then drain
    step(1, enc(3'd0, 8, 5'd13, 5'd2, 4'h0), pat, 32'd4, 0, "R8");
    step(1, enc(3'd0, 8, 5'd14, 5'd2, 4'h0), 32'd0, 32'd0, 0, "R9");
    step(1, enc(3'd0, 8, 5'd14, 5'd2, 4'h0), 32'd0, 32'd0, 0, "R9");
    step(1, enc(3'd4, 8, 5'd15, 5'd8, 4'h0), pat, 32'd0, 1, "R9");
    step(0, '0, '0, '0, 1, "R9");
    // R10 reset with a beat held
    step(1, enc(3'd6, 8, 5'd16, 5'd2, 4'h0), pat, 32'd0, 0, "R10");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_valid = 0; m_we = 0; m_ill = 0;
    compare("R10");
    // mixed traffic with random back-pressure
    for (int k = 0; k < 300; k++) begin
      logic [31:0] r = $urandom;
      logic [2:0]  f3 = (r[3:0] < 4'd6) ? 3'd0 : ((r[3:0] < 4'd13) ? 3'd4 : r[6:4]);
      logic [31:0] b = r[7] ? 32'($urandom_range(0, 40)) : $urandom;
      logic [31:0] ins = enc(f3, int'(r[10:8]) + 1, r[15:11], r[20:16], r[24:21]);
      if (r[25] && r[26]) ins[6:0] = 7'h2B;
      step(r[27] | r[28], ins, $urandom, b, r[29] | r[30], "R5");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule